// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds a processor's status word. Its low eight bits are flags. Four of them are condition flags that follow the arithmetic unit: carry, zero, sign and overflow. The other four are control flags: single-step debug, register bank choice, interrupt enable and stack pointer choice. The status word is twelve bits wide, and its top four bits are reserved.

Each cycle, the register takes in several things:
- a result bundle from the arithmetic unit, with a separate update enable for each condition flag;
- a whole-register write from software;
- an interrupt-acknowledge strobe, which carries a hardware/software indicator and a software interrupt number;
- an instruction-complete strobe.

An acknowledge clears the debug and interrupt-enable flags. It also returns the stack pointer choice to the interrupt stack, for hardware interrupts and for low-numbered software interrupts only. While the debug flag is set, each completed instruction raises a one-cycle single-step request.

Its outputs drive the neighbouring blocks: bank select goes to the register file, stack select goes to the stack pointer logic, and the enable and step request go to the interrupt controller.

Top module: `flg_status_reg`

## Requirements
- R1: A synchronous active-high reset clears all twelve bits of `flags_q` and clears `step_req`.
- R2: Flag positions are C=bit0, D=bit1, Z=bit2, S=bit3, B=bit4, O=bit5, I=bit6, U=bit7. A cycle with `wr_en` high loads `wr_data[7:0]` into these bits on the next clock edge.
- R3: Bits 11..8 of `flags_q` always read 0, whatever is written to them.
- R4: When `upd_c` is high and `wr_en` is low, C takes the value of `alu_cy`.
- R5: When their enables are high and `wr_en` is low, Z becomes 1 exactly when `alu_res` is all zeros, and S takes the most significant bit of `alu_res`.
- R6: When `upd_o` is high and `wr_en` is low, O takes the value of `alu_ov`. A condition flag whose enable is low keeps its value.
- R7: In a cycle with `wr_en` high, the written value replaces the condition flags, and all arithmetic update enables are ignored.
- R8: An acknowledge (`ack` high) clears D and I on the next edge, even over a value written in the same cycle.
- R9: An acknowledge with `ack_hw`=1, or with `ack_hw`=0 and `ack_num` < 32, clears U. A software acknowledge with `ack_num` >= 32 leaves U at the value it would otherwise take.
- R10: `bank_sel` equals B, `sp_user` equals U, and `irq_en` equals I, all three registered.
- R11: When `insn_done` is high while D is 1 and `ack` is low, `step_req` is high for exactly the next cycle. An acknowledge in the same cycle suppresses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_res | input | DATA_W | Arithmetic result value |
| alu_cy | input | 1 | Carry, borrow or shifted-out bit |
| alu_ov | input | 1 | Signed overflow indication |
| upd_c | input | 1 | Update enable for C |
| upd_z | input | 1 | Update enable for Z |
| upd_s | input | 1 | Update enable for S |
| upd_o | input | 1 | Update enable for O |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | REG_W | Software write value |
| ack | input | 1 | Interrupt acknowledge strobe |
| ack_hw | input | 1 | 1 = hardware interrupt, 0 = software |
| ack_num | input | NUM_W | Software interrupt number |
| insn_done | input | 1 | Instruction completed this cycle |
| flags_q | output | REG_W | Status register value |
| bank_sel | output | 1 | Register bank select |
| sp_user | output | 1 | 1 = user stack pointer, 0 = interrupt stack pointer |
| irq_en | output | 1 | Maskable interrupt enable |
| step_req | output | 1 | Single-step interrupt request pulse |

## Verification
Every result of this block is due one clock edge after its stimulus. The register contents, the three select outputs and the step pulse all come from a single register stage, and none of them has a combinational path from the inputs. The bench drives each stimulus on a falling edge and lets one rising edge pass. It then samples mid-cycle, before it drives the next stimulus, so each check sees exactly that stimulus's effect. The step pulse's one-cycle width is checked by the vector after the one that raises it, which must show it low again.

// File: rtl/flg_pkg.sv
package flg_pkg;
  localparam int FLAG_W = 8;
  localparam int POS_C  = 0;
  localparam int POS_D  = 1;
  localparam int POS_Z  = 2;
  localparam int POS_S  = 3;
  localparam int POS_B  = 4;
  localparam int POS_O  = 5;
  localparam int POS_I  = 6;
  localparam int POS_U  = 7;
endpackage

// File: rtl/flg_cond_calc.sv
module flg_cond_calc
  import flg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] res,
  input  logic              cy,
  input  logic              ov,
  input  logic              upd_c,
  input  logic              upd_z,
  input  logic              upd_s,
  input  logic              upd_o,
  input  logic [FLAG_W-1:0] cur,
  output logic [FLAG_W-1:0] nxt
);
  logic is_zero;
  logic is_neg;

  assign is_zero = (res == '0);
  assign is_neg  = res[DATA_W-1];

  always_comb begin
    nxt = cur;
    if (upd_c) nxt[POS_C] = cy;
    if (upd_z) nxt[POS_Z] = is_zero;
    if (upd_s) nxt[POS_S] = is_neg;
    if (upd_o) nxt[POS_O] = ov;
  end
endmodule

// File: rtl/flg_ctrl_calc.sv
module flg_ctrl_calc
  import flg_pkg::*;
#(
  parameter int NUM_W     = 6,
  parameter int LOW_LIMIT = 32
) (
  input  logic [FLAG_W-1:0] base,
  input  logic              ack,
  input  logic              ack_hw,
  input  logic [NUM_W-1:0]  ack_num,
  output logic [FLAG_W-1:0] nxt
);
  localparam int CMP_W = NUM_W + 1;
  localparam logic [CMP_W-1:0] LIMIT_V = CMP_W'(LOW_LIMIT);

  logic num_low;
  logic clr_stack;

  assign num_low   = ({1'b0, ack_num} < LIMIT_V);
  assign clr_stack = ack && (ack_hw || num_low);

  always_comb begin
    nxt = base;
    if (ack) begin
      nxt[POS_D] = 1'b0;
      nxt[POS_I] = 1'b0;
    end
    if (clr_stack) nxt[POS_U] = 1'b0;
  end
endmodule

// File: rtl/flg_step_gen.sv
module flg_step_gen (
  input  logic clk,
  input  logic rst,
  input  logic insn_done,
  input  logic dbg,
  input  logic ack,
  output logic step_req
);
  always_ff @(posedge clk) begin
    if (rst) step_req <= 1'b0;
    else     step_req <= insn_done && dbg && !ack;
  end
endmodule

// File: rtl/flg_status_reg.sv
module flg_status_reg
  import flg_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int REG_W     = 12,
  parameter int NUM_W     = 6,
  parameter int LOW_LIMIT = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_cy,
  input  logic              alu_ov,
  input  logic              upd_c,
  input  logic              upd_z,
  input  logic              upd_s,
  input  logic              upd_o,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              ack,
  input  logic              ack_hw,
  input  logic [NUM_W-1:0]  ack_num,
  input  logic              insn_done,
  output logic [REG_W-1:0]  flags_q,
  output logic              bank_sel,
  output logic              sp_user,
  output logic              irq_en,
  output logic              step_req
);
  localparam int RSV_W = REG_W - FLAG_W;

  logic [FLAG_W-1:0] flg_r;
  logic [FLAG_W-1:0] cond_nxt;
  logic [FLAG_W-1:0] base_nxt;
  logic [FLAG_W-1:0] final_nxt;

  flg_cond_calc #(.DATA_W(DATA_W)) u_cond (
    .res(alu_res), .cy(alu_cy), .ov(alu_ov),
    .upd_c(upd_c), .upd_z(upd_z), .upd_s(upd_s), .upd_o(upd_o),
    .cur(flg_r), .nxt(cond_nxt)
  );

  assign base_nxt = wr_en ? wr_data[FLAG_W-1:0] : cond_nxt;

  flg_ctrl_calc #(.NUM_W(NUM_W), .LOW_LIMIT(LOW_LIMIT)) u_ctrl (
    .base(base_nxt), .ack(ack), .ack_hw(ack_hw), .ack_num(ack_num),
    .nxt(final_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) flg_r <= '0;
    else     flg_r <= final_nxt;
  end

  flg_step_gen u_step (
    .clk(clk), .rst(rst), .insn_done(insn_done),
    .dbg(flg_r[POS_D]), .ack(ack), .step_req(step_req)
  );

  generate
    if (RSV_W > 0) begin : g_rsv
      assign flags_q = {{RSV_W{1'b0}}, flg_r};
    end else begin : g_norsv
      assign flags_q = flg_r[REG_W-1:0];
    end
  endgenerate

  assign bank_sel = flg_r[POS_B];
  assign sp_user  = flg_r[POS_U];
  assign irq_en   = flg_r[POS_I];
endmodule

// File: rtl/flg_status_reg_chk.sv
module flg_status_reg_chk #(
  parameter int DATA_W    = 8,
  parameter int REG_W     = 12,
  parameter int NUM_W     = 6,
  parameter int LOW_LIMIT = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] alu_res,
  input logic              alu_cy,
  input logic              upd_c,
  input logic              upd_z,
  input logic              wr_en,
  input logic              ack,
  input logic              ack_hw,
  input logic [NUM_W-1:0]  ack_num,
  input logic              insn_done,
  input logic [REG_W-1:0]  flags_q,
  input logic              step_req
);
  assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (rst)
    flags_q[REG_W-1:8] == '0);

  assert_carry_load_R4: assert property (@(posedge clk) disable iff (rst)
    (upd_c && !wr_en && !ack) |=> flags_q[0] == $past(alu_cy));

  assert_zero_detect_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_z && !wr_en) |=> flags_q[2] == ($past(alu_res) == '0));

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
    ack |=> (!flags_q[1] && !flags_q[6]));

  assert_hw_stack_R9: assert property (@(posedge clk) disable iff (rst)
    (ack && ack_hw) |=> !flags_q[7]);

  assert_high_swi_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (ack && !ack_hw && ({1'b0, ack_num} >= (NUM_W+1)'(LOW_LIMIT)) && !wr_en)
      |=> flags_q[7] == $past(flags_q[7]));

  assert_step_raise_R11: assert property (@(posedge clk) disable iff (rst)
    (insn_done && flags_q[1] && !ack) |=> step_req);

  assert_step_suppress_R11: assert property (@(posedge clk) disable iff (rst)
    (ack || !insn_done) |=> !step_req);
endmodule

bind flg_status_reg flg_status_reg_chk #(
  .DATA_W(DATA_W), .REG_W(REG_W), .NUM_W(NUM_W), .LOW_LIMIT(LOW_LIMIT)
) u_chk (
  .clk(clk), .rst(rst), .alu_res(alu_res), .alu_cy(alu_cy),
  .upd_c(upd_c), .upd_z(upd_z), .wr_en(wr_en), .ack(ack),
  .ack_hw(ack_hw), .ack_num(ack_num), .insn_done(insn_done),
  .flags_q(flags_q), .step_req(step_req)
);

// File: tb/sim_flg_status_reg.sv
module sim_flg_status_reg;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  alu_res;
  logic        alu_cy, alu_ov, upd_c, upd_z, upd_s, upd_o;
  logic        wr_en;
  logic [11:0] wr_data;
  logic        ack, ack_hw;
  logic [5:0]  ack_num;
  logic        insn_done;
  logic [11:0] flags_q;
  logic        bank_sel, sp_user, irq_en, step_req;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  flg_status_reg u0 (
    .clk(clk), .rst(rst), .alu_res(alu_res), .alu_cy(alu_cy), .alu_ov(alu_ov),
    .upd_c(upd_c), .upd_z(upd_z), .upd_s(upd_s), .upd_o(upd_o),
    .wr_en(wr_en), .wr_data(wr_data), .ack(ack), .ack_hw(ack_hw),
    .ack_num(ack_num), .insn_done(insn_done), .flags_q(flags_q),
    .bank_sel(bank_sel), .sp_user(sp_user), .irq_en(irq_en), .step_req(step_req)
  );

  // {wr, wdata[12], res[8], cy, ov, uc, uz, us, uo, ack, hw, num[6], done, expf[12], exps}
  localparam int NV = 16;
  localparam logic [48:0] VEC [NV] = '{
    {1'b1, 12'h0FF, 8'h00, 6'b000000, 1'b0, 1'b0, 6'd0,  1'b0, 12'h0FF, 1'b0},
    {1'b0, 12'h000, 8'h00, 6'b000000, 1'b1, 1'b1, 6'd0,  1'b0, 12'h03D, 1'b0},
    {1'b1, 12'h0C2, 8'h00, 6'b000000, 1'b0, 1'b0, 6'd0,  1'b1, 12'h0C2, 1'b0},
    {1'b0, 12'h000, 8'h00, 6'b000000, 1'b0, 1'b0, 6'd0,  1'b1, 12'h0C2, 1'b1},
    {1'b0, 12'h000, 8'h00, 6'b000000, 1'b0, 1'b0, 6'd0,  1'b0, 12'h0C2, 1'b0},
    {1'b0, 12'h000, 8'h00, 6'b000000, 1'b1, 1'b0, 6'd40, 1'b1, 12'h080, 1'b0},
    {1'b0, 12'h000, 8'h00, 6'b000000, 1'b1, 1'b0, 6'd31, 1'b0, 12'h000, 1'b0},
    {1'b0, 12'h000, 8'h00, 6'b101111, 1'b0, 1'b0, 6'd0,  1'b0, 12'h005, 1'b0},
    {1'b0, 12'h000, 8'h80, 6'b011111, 1'b0, 1'b0, 6'd0,  1'b0, 12'h028, 1'b0},
    {1'b0, 12'h000, 8'h7F, 6'b101000, 1'b0, 1'b0, 6'd0,  1'b0, 12'h029, 1'b0},
    {1'b1, 12'h010, 8'h00, 6'b101111, 1'b0, 1'b0, 6'd0,  1'b0, 12'h010, 1'b0},
    {1'b1, 12'h0C2, 8'h00, 6'b000000, 1'b1, 1'b1, 6'd63, 1'b0, 12'h000, 1'b0},
    {1'b1, 12'h0C0, 8'h00, 6'b000000, 1'b1, 1'b0, 6'd32, 1'b0, 12'h080, 1'b0},
    {1'b1, 12'hF3C, 8'h00, 6'b000000, 1'b0, 1'b0, 6'd0,  1'b0, 12'h03C, 1'b0},
    {1'b0, 12'h000, 8'h01, 6'b000110, 1'b0, 1'b0, 6'd0,  1'b0, 12'h030, 1'b0},
    {1'b0, 12'h000, 8'hFF, 6'b000000, 1'b0, 1'b0, 6'd0,  1'b1, 12'h030, 1'b0}
  };

  function automatic string vec_tag(int i);
    case (i)
      0:       return "R2";
      1:       return "R8";
      2, 4:    return "R11";
      3:       return "R11";
      5:       return "R9";
      6:       return "R9";
      7:       return "R4";
      8:       return "R5";
      9:       return "R6";
      10:      return "R7";
      11:      return "R8";
      12:      return "R9";
      13:      return "R3";
      14:      return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic idle_inputs();
    alu_res = '0; alu_cy = 0; alu_ov = 0;
    upd_c = 0; upd_z = 0; upd_s = 0; upd_o = 0;
    wr_en = 0; wr_data = '0; ack = 0; ack_hw = 0; ack_num = '0; insn_done = 0;
  endtask

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  initial begin : watchdog
    #2000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #5;
    check("R1 reset", {3'b0, step_req, flags_q}, 16'h0000);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [48:0] v;
      v = VEC[i];
      wr_en     = v[48];
      wr_data   = v[47:36];
      alu_res   = v[35:28];
      alu_cy    = v[27];
      alu_ov    = v[26];
      upd_c     = v[25];
      upd_z     = v[24];
      upd_s     = v[23];
      upd_o     = v[22];
      ack       = v[21];
      ack_hw    = v[20];
      ack_num   = v[19:14];
      insn_done = v[13];
      @(posedge clk);
      #5;
      check(vec_tag(i), {3'b0, step_req, flags_q}, {3'b0, v[0], v[12:1]});
      // R10 outputs mirror B, U, I
      check("R10", {13'b0, bank_sel, sp_user, irq_en},
            {13'b0, v[5], v[8], v[7]});
      @(negedge clk);
      idle_inputs();
    end

    // R1: reset mid-run with state set and step pending
    wr_en = 1; wr_data = 12'h0FF;
    @(negedge clk);
    idle_inputs(); insn_done = 1; rst = 1;
    @(posedge clk);
    #5;
    check("R1 mid-run reset", {3'b0, step_req, flags_q}, 16'h0000);
    @(negedge clk);
    rst = 0; insn_done = 0;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule